// File: doc/BRIEF.md
# Command Completion Counter and Level Interrupt

This block keeps the completion accounting for one channel of a list-driven DMA engine. The list engine sends a single-cycle pulse each time it finishes a command. The block counts these pulses in a 6-bit hardware count that wraps modulo 64. Software keeps its own 6-bit acknowledged count in the same status word.

While the two counts differ and the channel's interrupt enables are all set, the block raises an interrupt-active flag and drives a level interrupt, active high. Software acknowledges by writing the status word. It copies the done count it last read into the acknowledged field. The write never clears or overwrites the done count, so a command that finishes in the same cycle as the write is kept. A second read then shows that command, and the interrupt comes back on the next cycle.

The interrupt enables come from the channel's general configuration word. Only bits 31, 29 and 28 of that word are decoded.

Top module: `cmd_done_irq`

## Requirements
- R1: After a synchronous reset, the status word reads 32'h0000_0000 and the interrupt line is low.
- R2: Each cycle with the event pulse high adds one to the done count, which is status bits 5:0. The count wraps from 63 to 0. With no pulse, the done count holds.
- R3: A status write loads the acknowledged count, status bits 21:16, from write-data bits 21:16. All other write-data bits are ignored, and the done count is never written. Status bits outside 21:16, 8 and 5:0 always read 0.
- R4: An event pulse and a write in the same cycle both take effect. The done count increments, and the acknowledged count takes the written value.
- R5: After a write cycle, the interrupt-active flag (status bit 8) reads 0. If no further write follows and the counts still differ, the flag reads 1 again one cycle later.
- R6: After a cycle with no write, the flag reads 1 exactly when the done count and the acknowledged count differ and the interrupts are enabled.
- R7: Interrupts are enabled only when bits 31, 29 and 28 of the configuration word are all 1. If any of the three is 0, the flag and the interrupt line stay low, and the done count still counts.
- R8: The interrupt line always equals status bit 8.
- R9: Pending work is (done − acknowledged) mod 64. When the done count has wrapped below the acknowledged count, the work is still pending and the flag is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| done_evt_i | input | 1 | One-cycle command-completed pulse from the list engine |
| cfg_i | input | 32 | Channel general configuration word; bits 31, 29 and 28 are the interrupt enables |
| st_wr_i | input | 1 | Status write strobe |
| st_wdata_i | input | 32 | Status write data; bits 21:16 are the new acknowledged count |
| status_o | output | 32 | Status word: done count in 5:0, interrupt active in 8, acknowledged count in 21:16 |
| irq_o | output | 1 | Level interrupt, active high |

## Verification
The assertions check, on every cycle, four rules. The done count moves only on a pulse, and every pulse moves it. A write lands in the acknowledged field and forces the flag low for the following cycle. Equal counts or disabled enables keep the interrupt low.

Some behaviour can only be shown by the bench's scenarios. These are the modulo-64 wrap of the done count below the acknowledged count, the re-assertion one cycle after an acknowledge that left work pending, and a pulse that coincides with a write. The bench also shows that bits of the write data outside the acknowledged field are ignored.

// File: rtl/cmd_done_irq_pkg.sv
package cmd_done_irq_pkg;
  localparam int STW      = 32;
  localparam int DONE_LSB = 0;
  localparam int ACT_BIT  = 8;
  localparam int ACK_LSB  = 16;
  localparam int EN_LIST  = 31;
  localparam int EN_CMD   = 29;
  localparam int EN_LEVEL = 28;
endpackage

// File: rtl/cdi_done_ctr.sv
module cdi_done_ctr #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             evt_i,
  output logic [CNT_W-1:0] cnt_next_o,
  output logic [CNT_W-1:0] cnt_o
);
  always_comb cnt_next_o = cnt_o + CNT_W'(evt_i);

  always_ff @(posedge clk) begin
    if (rst) cnt_o <= '0;
    else     cnt_o <= cnt_next_o;
  end

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !evt_i |=> $stable(cnt_o)); // R2
  AST_DONE_MOVES: assert property (@(posedge clk) disable iff (rst)
    evt_i |=> (cnt_o != $past(cnt_o))); // R2
endmodule

// File: rtl/cdi_ack_reg.sv
module cdi_ack_reg #(
  parameter int CNT_W = 6,
  parameter int LSB   = 16,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [CNT_W-1:0] ack_next_o,
  output logic [CNT_W-1:0] ack_o
);
  always_comb ack_next_o = wr_i ? wdata_i[LSB +: CNT_W] : ack_o;

  always_ff @(posedge clk) begin
    if (rst) ack_o <= '0;
    else     ack_o <= ack_next_o;
  end

  AST_ACK_LOAD: assert property (@(posedge clk) disable iff (rst)
    wr_i |=> (ack_o == $past(wdata_i[LSB +: CNT_W]))); // R3
  AST_ACK_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_i |=> $stable(ack_o)); // R3
endmodule

// File: rtl/cdi_irq_gen.sv
module cdi_irq_gen #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] done_next_i,
  input  logic [CNT_W-1:0] ack_next_i,
  output logic             act_o
);
  logic pend;
  always_comb pend = (done_next_i - ack_next_i) != '0;

  always_ff @(posedge clk) begin
    if (rst)       act_o <= 1'b0;
    else if (wr_i) act_o <= 1'b0;
    else           act_o <= pend & en_i;
  end

  AST_WR_CLEARS: assert property (@(posedge clk) disable iff (rst)
    wr_i |=> !act_o); // R5
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> !act_o); // R7
endmodule

// File: rtl/cmd_done_irq.sv
module cmd_done_irq
  import cmd_done_irq_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           done_evt_i,
  input  logic [STW-1:0] cfg_i,
  input  logic           st_wr_i,
  input  logic [STW-1:0] st_wdata_i,
  output logic [STW-1:0] status_o,
  output logic           irq_o
);
  logic [CNT_W-1:0] done_q, done_d, ack_q, ack_d;
  logic             act_q, irq_en;

  always_comb irq_en = cfg_i[EN_LIST] & cfg_i[EN_CMD] & cfg_i[EN_LEVEL];

  cdi_done_ctr #(.CNT_W(CNT_W)) u_done (
    .clk(clk), .rst(rst), .evt_i(done_evt_i),
    .cnt_next_o(done_d), .cnt_o(done_q));

  cdi_ack_reg #(.CNT_W(CNT_W), .LSB(ACK_LSB), .DW(STW)) u_ack (
    .clk(clk), .rst(rst), .wr_i(st_wr_i), .wdata_i(st_wdata_i),
    .ack_next_o(ack_d), .ack_o(ack_q));

  cdi_irq_gen #(.CNT_W(CNT_W)) u_irq (
    .clk(clk), .rst(rst), .en_i(irq_en), .wr_i(st_wr_i),
    .done_next_i(done_d), .ack_next_i(ack_d), .act_o(act_q));

  always_comb begin
    status_o = '0;
    status_o[DONE_LSB +: CNT_W] = done_q;
    status_o[ACT_BIT]           = act_q;
    status_o[ACK_LSB +: CNT_W]  = ack_q;
    irq_o = act_q;
  end

  AST_EQUAL_NO_IRQ: assert property (@(posedge clk) disable iff (rst)
    (status_o[DONE_LSB +: CNT_W] == status_o[ACK_LSB +: CNT_W]) |-> !irq_o); // R6
  AST_DONE_SURVIVES_WR: assert property (@(posedge clk) disable iff (rst)
    (st_wr_i && !done_evt_i) |=> $stable(status_o[DONE_LSB +: CNT_W])); // R4
endmodule

// File: tb/cmd_done_irq_tb_top.sv
module cmd_done_irq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] CFG_ON  = 32'hB000_0000;
  localparam logic [31:0] CFG_OFF = 32'hA000_0000;

  logic clk = 1'b0, rst = 1'b1, evt = 1'b0, wr = 1'b0;
  logic [31:0] cfg = CFG_ON, wdata = '0;
  logic [31:0] status;
  logic irq;
  int n_vec = 0, n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_done_irq dut_i (
    .clk(clk), .rst(rst), .done_evt_i(evt), .cfg_i(cfg),
    .st_wr_i(wr), .st_wdata_i(wdata), .status_o(status), .irq_o(irq));

  // evt, wr, wr_ack, en, exp_done, exp_ack, exp_act
  typedef struct packed {
    logic       e;
    logic       w;
    logic [5:0] wa;
    logic       en;
    logic [5:0] d;
    logic [5:0] a;
    logic       act;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{1'b1, 1'b0, 6'd0, 1'b1, 6'd1, 6'd0, 1'b1},  // R2 R6
    '{1'b1, 1'b0, 6'd0, 1'b1, 6'd2, 6'd0, 1'b1},  // R2
    '{1'b0, 1'b1, 6'd2, 1'b1, 6'd2, 6'd2, 1'b0},  // R3 R5
    '{1'b0, 1'b0, 6'd0, 1'b1, 6'd2, 6'd2, 1'b0},  // R6
    '{1'b1, 1'b1, 6'd2, 1'b1, 6'd3, 6'd2, 1'b0},  // R4 R5
    '{1'b0, 1'b0, 6'd0, 1'b1, 6'd3, 6'd2, 1'b1},  // R5 re-assert
    '{1'b0, 1'b1, 6'd3, 1'b0, 6'd3, 6'd3, 1'b0},  // R3
    '{1'b1, 1'b0, 6'd0, 1'b0, 6'd4, 6'd3, 1'b0},  // R7
    '{1'b0, 1'b0, 6'd0, 1'b1, 6'd4, 6'd3, 1'b1},  // R6
    '{1'b0, 1'b1, 6'd4, 1'b1, 6'd4, 6'd4, 1'b0}   // R5
  };

  task automatic check(input string req, input logic [31:0] exp);
    n_vec++;
    if (status !== exp) begin
      n_bad++;
      $display("FAIL %s status act=%h exp=%h", req, status, exp);
    end
    if (irq !== exp[8]) begin
      n_bad++;
      $display("FAIL R8 (%s) irq act=%b exp=%b", req, irq, exp[8]);
    end
  endtask

  function automatic logic [31:0] mk(input logic [5:0] d, input logic [5:0] a,
                                     input logic act);
    mk = {10'd0, a, 7'd0, act, 2'd0, d};
  endfunction

  task automatic step(input logic e, input logic w, input logic [31:0] wd,
                      input logic [31:0] c);
    @(negedge clk);
    evt = e; wr = w; wdata = wd; cfg = c;
    @(posedge clk);
    #1;
    evt = 1'b0; wr = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1", 32'h0);
    @(negedge clk); rst = 1'b0;

    foreach (VECS[i]) begin
      step(VECS[i].e, VECS[i].w, {10'd0, VECS[i].wa, 16'd0},
           VECS[i].en ? CFG_ON : CFG_OFF);
      check($sformatf("vec%0d R2-R7", i), mk(VECS[i].d, VECS[i].a, VECS[i].act));
    end

    // R9: acknowledged 60, done 4 -> pending, then wrap done through 63 to 0
    step(1'b0, 1'b1, {10'd0, 6'd60, 16'd0}, CFG_ON);
    check("R9 ack above done", mk(6'd4, 6'd60, 1'b0));
    step(1'b0, 1'b0, '0, CFG_ON);
    check("R9 pending after wrap gap", mk(6'd4, 6'd60, 1'b1));
    for (int k = 0; k < 60; k++) step(1'b1, 1'b0, '0, CFG_ON);
    check("R2 wrap to zero", mk(6'd0, 6'd60, 1'b1));
    for (int k = 0; k < 4; k++) step(1'b1, 1'b0, '0, CFG_ON);
    check("R9 wrapped done below ack", mk(6'd4, 6'd60, 1'b1));

    // R3: only bits 21:16 of write data matter
    step(1'b0, 1'b1, 32'hFFC4_FFFF, CFG_ON);
    check("R3 stray write bits", 32'h0004_0004);
    step(1'b0, 1'b0, '0, CFG_ON);
    check("R6 equal stays low", 32'h0004_0004);

    // R7: only one enable bit cleared (bit 29)
    step(1'b1, 1'b0, '0, 32'h9000_0000);
    check("R7 cmd enable off", mk(6'd5, 6'd4, 1'b0));
    step(1'b0, 1'b0, '0, CFG_ON);
    check("R7 enable restored", mk(6'd5, 6'd4, 1'b1));

    // R1: reset mid-run
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    check("R1 reset mid-run", 32'h0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule